// File: doc/BRIEF.md
# Exception Cause Capture and Dispatch

This unit sits beside the fetch stage of a simple in-order CPU. Each cycle it looks at two fault detectors, one for an unrecognised opcode and one for an arithmetic overflow. When a fault is seen and exceptions are enabled, it does three things in the same cycle. It raises the write enables for the saved-PC register and the cause register. It loads the faulting instruction's PC and a numeric cause code into them on the next clock edge. It steers fetch to a handler address.

A mode input selects how the handler address is found. In single-entry mode every cause goes to one fixed address, and the handler reads the cause register to learn what happened. In vectored mode each cause has its own entry point, spaced at a fixed stride from a base. A return strobe sends fetch back to the saved PC so the interrupted program can resume. A global enable masks capture. A masked fault writes nothing and produces no redirect.

Top module: `exc_dispatch`

## Requirements
- R1: After reset the saved PC and the cause register both read 0. No redirect is requested and both write enables are low.
- R2: When `exc_en` is high and `undef_det` is high, `epc_we` and `cause_we` are high in that same cycle. After the next rising edge `epc_q` holds the `cur_pc` of that cycle and `cause_q` holds code 0.
- R3: When `exc_en` is high and only `ovf_det` is high, the capture happens as in R2 but `cause_q` receives code 1.
- R4: When both detectors are high in one enabled cycle, the unrecognised opcode wins. The cause is 0 and the redirect target is the one for code 0.
- R5: With `vec_mode` low, a taken exception sets `redirect_vld` high and `redirect_pc` to 0x80000180, whatever the cause.
- R6: With `vec_mode` high, a taken exception sends code 0 to 0xC0000000 and code 1 to 0xC0000020.
- R7: With `exc_en` low, a detector pulse raises neither write enable, raises no redirect, and leaves `epc_q` and `cause_q` unchanged.
- R8: A cycle with `eret` high and no taken exception sets `redirect_vld` high and `redirect_pc` to the current `epc_q`. Neither register is written.
- R9: If an exception is taken in the same cycle as `eret`, the exception's handler address is output and the capture happens. The return is dropped.
- R10: In a cycle with no taken exception and no `eret`, `redirect_vld` is low and both registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| exc_en | input | 1 | Global exception enable; low masks capture |
| undef_det | input | 1 | Unrecognised opcode detected (cause code 0) |
| ovf_det | input | 1 | Arithmetic overflow detected (cause code 1) |
| cur_pc | input | XLEN | PC of the instruction being checked |
| vec_mode | input | 1 | 0: single handler entry, 1: per-cause vectored entry |
| eret | input | 1 | Return-from-exception strobe |
| redirect_vld | output | 1 | Fetch must load `redirect_pc` this cycle |
| redirect_pc | output | XLEN | Handler address or return address |
| epc_we | output | 1 | Saved-PC register write enable |
| cause_we | output | 1 | Cause register write enable |
| epc_q | output | XLEN | Saved-PC register contents |
| cause_q | output | CAUSE_W | Cause register contents |

## Verification
The capture and dispatch path is driven with each detector alone, with both together, and with neither, in both dispatch modes. This separates a wrong cause code from a wrong priority, and a mode-independent target from a per-cause vector. Masked faults are followed by idle cycles, so any stray write would show up in the register outputs. Returns are issued after captures of distinct PCs and in the same cycle as a fault. This tells a return that reads stale or wrong state apart from one that wrongly overrides the handler.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
  // Source index doubles as cause code; lower index has higher priority.
  localparam int unsigned NUM_SRC    = 2;
  localparam int unsigned CODE_UNDEF = 0;
  localparam int unsigned CODE_OVF   = 1;
  localparam int unsigned CODE_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  localparam logic [31:0] SINGLE_ENTRY = 32'h8000_0180;
  localparam logic [31:0] VEC_BASE     = 32'hC000_0000;
  localparam int unsigned VEC_STRIDE   = 32'h20;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_TRAP = 2'd1,
    RD_RET  = 2'd2
  } redir_e;
endpackage

// File: rtl/exc_rst_sync.sv
`timescale 1ns/1ps
module exc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/exc_prio.sv
`timescale 1ns/1ps
module exc_prio #(
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned CODE_W  = 1
) (
  input  logic [NUM_SRC-1:0] det,
  input  logic               enable,
  output logic               take,
  output logic [CODE_W-1:0]  code
);
  logic [CODE_W-1:0] code_sel;

  // Scan from highest index down so the lowest set index wins.
  always_comb begin
    code_sel = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (det[i]) begin
        code_sel = CODE_W'(i);
      end
    end
  end

  assign take = enable & (|det);
  assign code = code_sel;
endmodule

// File: rtl/exc_target.sv
`timescale 1ns/1ps
module exc_target #(
  parameter int unsigned XLEN         = 32,
  parameter int unsigned CODE_W       = 1,
  parameter logic [XLEN-1:0] SINGLE_ENTRY = 32'h8000_0180,
  parameter logic [XLEN-1:0] VEC_BASE     = 32'hC000_0000,
  parameter int unsigned VEC_STRIDE   = 32
) (
  input  logic              vec_mode,
  input  logic [CODE_W-1:0] code,
  output logic [XLEN-1:0]   target
);
  logic [XLEN-1:0] vec_off;
  logic [XLEN-1:0] vec_addr;

  always_comb begin
    vec_off  = XLEN'(code) * XLEN'(VEC_STRIDE);
    vec_addr = VEC_BASE + vec_off;
    target   = vec_mode ? vec_addr : SINGLE_ENTRY;
  end
endmodule

// File: rtl/exc_regs.sv
`timescale 1ns/1ps
module exc_regs #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               epc_we,
  input  logic               cause_we,
  input  logic [XLEN-1:0]    epc_d,
  input  logic [CAUSE_W-1:0] cause_d,
  output logic [XLEN-1:0]    epc_q,
  output logic [CAUSE_W-1:0] cause_q
);
  logic [XLEN-1:0]    epc_nxt;
  logic [CAUSE_W-1:0] cause_nxt;

  always_comb begin
    epc_nxt   = epc_q;
    cause_nxt = cause_q;
    if (epc_we) begin
      epc_nxt = epc_d;
    end
    if (cause_we) begin
      cause_nxt = cause_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
    end else begin
      epc_q   <= epc_nxt;
      cause_q <= cause_nxt;
    end
  end
endmodule

// File: rtl/exc_dispatch.sv
`timescale 1ns/1ps
module exc_dispatch #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_en,
  input  logic               undef_det,
  input  logic               ovf_det,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic               vec_mode,
  input  logic               eret,
  output logic               redirect_vld,
  output logic [XLEN-1:0]    redirect_pc,
  output logic               epc_we,
  output logic               cause_we,
  output logic [XLEN-1:0]    epc_q,
  output logic [CAUSE_W-1:0] cause_q
);
  import exc_pkg::*;

  localparam int unsigned NSRC  = NUM_SRC;
  localparam int unsigned CW    = CODE_W;

  logic              rst_ns;
  logic [NSRC-1:0]   det_vec;
  logic              take;
  logic [CW-1:0]     code;
  logic [XLEN-1:0]   handler_pc;
  logic [CAUSE_W-1:0] cause_d;
  redir_e            redir_sel;

  exc_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  always_comb begin
    det_vec             = '0;
    det_vec[CODE_UNDEF] = undef_det;
    det_vec[CODE_OVF]   = ovf_det;
  end

  exc_prio #(.NUM_SRC(NSRC), .CODE_W(CW)) i_prio (
    .det    (det_vec),
    .enable (exc_en),
    .take   (take),
    .code   (code)
  );

  exc_target #(
    .XLEN         (XLEN),
    .CODE_W       (CW),
    .SINGLE_ENTRY (XLEN'(SINGLE_ENTRY)),
    .VEC_BASE     (XLEN'(VEC_BASE)),
    .VEC_STRIDE   (VEC_STRIDE)
  ) i_target (
    .vec_mode (vec_mode),
    .code     (code),
    .target   (handler_pc)
  );

  assign cause_d = CAUSE_W'(code);

  exc_regs #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) i_regs (
    .clk      (clk),
    .rst_n    (rst_ns),
    .epc_we   (epc_we),
    .cause_we (cause_we),
    .epc_d    (cur_pc),
    .cause_d  (cause_d),
    .epc_q    (epc_q),
    .cause_q  (cause_q)
  );

  // A trap outranks a return in the same cycle.
  always_comb begin
    if (take) begin
      redir_sel = RD_TRAP;
    end else if (eret) begin
      redir_sel = RD_RET;
    end else begin
      redir_sel = RD_NONE;
    end
  end

  always_comb begin
    epc_we       = 1'b0;
    cause_we     = 1'b0;
    redirect_vld = 1'b0;
    redirect_pc  = '0;
    if (rst_ns) begin
      unique case (redir_sel)
        RD_TRAP: begin
          epc_we       = 1'b1;
          cause_we     = 1'b1;
          redirect_vld = 1'b1;
          redirect_pc  = handler_pc;
        end
        RD_RET: begin
          redirect_vld = 1'b1;
          redirect_pc  = epc_q;
        end
        default: begin
          redirect_vld = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/exc_dispatch_chk.sv
`timescale 1ns/1ps
module exc_dispatch_chk #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               exc_en,
  input logic               undef_det,
  input logic               ovf_det,
  input logic [XLEN-1:0]    cur_pc,
  input logic               vec_mode,
  input logic               eret,
  input logic               redirect_vld,
  input logic [XLEN-1:0]    redirect_pc,
  input logic               epc_we,
  input logic               cause_we,
  input logic [XLEN-1:0]    epc_q,
  input logic [CAUSE_W-1:0] cause_q
);
  AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_en && undef_det) |=> (epc_q == $past(cur_pc) && cause_q == '0)); // R2

  AST_OVF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_en && ovf_det && !undef_det) |=> (cause_q == CAUSE_W'(1))); // R3

  AST_PRIO_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_en && undef_det && ovf_det && vec_mode) |-> (redirect_pc == XLEN'(32'hC000_0000))); // R4

  AST_SINGLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_en && (undef_det || ovf_det) && !vec_mode) |-> (redirect_vld && redirect_pc == XLEN'(32'h8000_0180))); // R5

  AST_VEC_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_en && ovf_det && !undef_det && vec_mode) |-> (redirect_pc == XLEN'(32'hC000_0020))); // R6

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_en) |=> ($stable(epc_q) && $stable(cause_q))); // R7

  AST_MASK_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_en) |-> (!epc_we && !cause_we)); // R7

  AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !(exc_en && (undef_det || ovf_det))) |-> (redirect_vld && redirect_pc == epc_q)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!eret && !(exc_en && (undef_det || ovf_det))) |-> (!redirect_vld)); // R10
endmodule

bind exc_dispatch exc_dispatch_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_ns),
  .exc_en       (exc_en),
  .undef_det    (undef_det),
  .ovf_det      (ovf_det),
  .cur_pc       (cur_pc),
  .vec_mode     (vec_mode),
  .eret         (eret),
  .redirect_vld (redirect_vld),
  .redirect_pc  (redirect_pc),
  .epc_we       (epc_we),
  .cause_we     (cause_we),
  .epc_q        (epc_q),
  .cause_q      (cause_q)
);

// File: tb/test_exc_dispatch.sv
`timescale 1ns/1ps
module test_exc_dispatch;
  localparam int XLEN    = 32;
  localparam int CAUSE_W = 5;

  logic               clk;
  logic               rst_n;
  logic               exc_en;
  logic               undef_det;
  logic               ovf_det;
  logic [XLEN-1:0]    cur_pc;
  logic               vec_mode;
  logic               eret;
  logic               redirect_vld;
  logic [XLEN-1:0]    redirect_pc;
  logic               epc_we;
  logic               cause_we;
  logic [XLEN-1:0]    epc_q;
  logic [CAUSE_W-1:0] cause_q;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  typedef struct {
    bit                 vld;
    logic [XLEN-1:0]    pc;
    bit                 we;
    logic [XLEN-1:0]    epc;
    logic [CAUSE_W-1:0] cause;
    string              req;
  } item_t;

  item_t sb_q[$];

  logic [XLEN-1:0]    m_epc;
  logic [CAUSE_W-1:0] m_cause;

  exc_dispatch #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) i_exc_dispatch (
    .clk          (clk),
    .rst_n        (rst_n),
    .exc_en       (exc_en),
    .undef_det    (undef_det),
    .ovf_det      (ovf_det),
    .cur_pc       (cur_pc),
    .vec_mode     (vec_mode),
    .eret         (eret),
    .redirect_vld (redirect_vld),
    .redirect_pc  (redirect_pc),
    .epc_we       (epc_we),
    .cause_we     (cause_we),
    .epc_q        (epc_q),
    .cause_q      (cause_q)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues what must be seen.
  task automatic step(input bit en, input bit u, input bit o,
                      input logic [XLEN-1:0] pc, input bit vm, input bit er,
                      input string req);
    item_t it;
    bit take;
    logic [CAUSE_W-1:0] cz;
    @(negedge clk);
    exc_en = en; undef_det = u; ovf_det = o; cur_pc = pc; vec_mode = vm; eret = er;
    #1;
    take = en && (u || o);
    cz   = u ? CAUSE_W'(0) : CAUSE_W'(1);
    it.we    = take;
    it.vld   = take || er;
    it.pc    = take ? (vm ? (u ? 32'hC000_0000 : 32'hC000_0020) : 32'h8000_0180)
                    : (er ? m_epc : '0);
    it.epc   = m_epc;
    it.cause = m_cause;
    it.req   = req;
    sb_q.push_back(it);
    if (take) begin
      m_epc   = pc;
      m_cause = cz;
    end
  endtask

  // Monitor: compares outputs mid-low-phase against queued expectations.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        chk(redirect_vld == it.vld, it.req, "redirect_vld", XLEN'(redirect_vld), XLEN'(it.vld));
        if (it.vld)
          chk(redirect_pc == it.pc, it.req, "redirect_pc", redirect_pc, it.pc);
        chk(epc_we == it.we && cause_we == it.we, it.req, "write_enables",
            XLEN'({epc_we, cause_we}), XLEN'({it.we, it.we}));
        chk(epc_q == it.epc, it.req, "epc_q", epc_q, it.epc);
        chk(cause_q == it.cause, it.req, "cause_q", XLEN'(cause_q), XLEN'(it.cause));
      end
    end
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; exc_en = 0; undef_det = 0; ovf_det = 0;
    cur_pc = '0; vec_mode = 0; eret = 0;
    m_epc = '0; m_cause = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    step(0, 0, 0, 32'h0, 0, 0, "R1");                 // reset state
    step(1, 1, 0, 32'h0000_1004, 0, 0, "R2_R5");      // undef, single entry
    step(1, 0, 1, 32'h0000_2008, 0, 0, "R3_R5");      // ovf, single entry
    step(1, 1, 1, 32'h0000_300C, 0, 0, "R4_R5");      // both, single entry
    step(1, 0, 0, 32'h0000_0000, 0, 0, "R10");        // idle, regs hold
    step(1, 1, 0, 32'h0000_4010, 1, 0, "R6_R2");      // undef, vectored
    step(1, 0, 1, 32'h0000_5014, 1, 0, "R6_R3");      // ovf, vectored
    step(1, 1, 1, 32'h0000_6018, 1, 0, "R4_R6");      // both, vectored
    step(1, 0, 0, 32'h0000_0000, 1, 1, "R8");         // return to 0x6018
    step(0, 1, 0, 32'h0000_701C, 1, 0, "R7");         // masked undef
    step(0, 0, 1, 32'h0000_8020, 0, 0, "R7");         // masked ovf
    step(0, 1, 1, 32'h0000_9024, 1, 0, "R7");         // masked both
    step(1, 0, 0, 32'h0000_0000, 0, 0, "R7_R10");     // regs unchanged
    step(0, 1, 0, 32'h0000_A028, 0, 1, "R7_R8");      // masked fault, return honoured
    step(1, 0, 1, 32'h0000_B02C, 1, 1, "R9");         // trap beats return
    step(1, 0, 0, 32'h0000_0000, 0, 1, "R8_R9");      // return to 0xB02C
    step(1, 1, 0, 32'hFFFF_FFFC, 0, 1, "R9");         // trap beats return, single
    step(0, 0, 0, 32'h0000_0000, 0, 0, "R10");
    for (int k = 0; k < 8; k++) begin
      step(1, k[0], !k[0], 32'h0001_0000 + 32'(k * 4), k[1], 0, "R2_R3_R6");
      step(1, 0, 0, 32'h0, 0, 1, "R8");
    end
    step(0, 0, 0, 32'h0, 0, 0, "R10");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule